// File: doc/BRIEF.md
# Locked Table-Entry Flag Updater

This block performs atomic flag updates on table entries that live in memory: segment descriptors, page-table and page-directory entries, and task-state descriptors. A command names the entry address, the kind of update and whether the legacy always-write rule applies. The engine then takes the shared bus under lock, reads the 64-bit entry, works out the new value, writes it back only when the update changes something (or when the legacy rule forces a write), and then drops the lock. Between the read and the write-or-skip decision, no other agent can touch the entry.

Completion is signalled by a one-cycle `done` pulse. For the task-claim operation, a busy flag that is already set means another agent owns the task. In that case nothing is written and `done_conflict` is raised with `done`. The engine serves one command at a time and ignores any command offered while it is working, including in the cycle `done` is high.

Top module: `flag_lock_engine`

## Requirements
- R1: After reset, `done`, `done_conflict`, `mem_lock` and `mem_req` are all low.
- R2: `mem_req` is high only while `mem_lock` and `mem_gnt` are both high. `mem_lock` stays high from the grant wait through the read, the decision and the write, and is low in the `done` cycle.
- R3: Operation 0 (segment access, `cmd_legacy`=0) sets bit 40 of the entry. It writes only when that bit was clear, so an entry with bit 40 set sees no write cycle.
- R4: Operation 0 with `cmd_legacy`=1 always writes the entry, with bit 40 set, whether or not the bit was already set.
- R5: Operation 1 (page entry read access) sets bit 5 and writes only when bit 5 was clear.
- R6: Operation 2 (page entry write access) sets bits 5 and 6 and writes unless both were already set.
- R7: Operation 3 (task claim) writes the entry with bit 41 set and reports `done_conflict`=0 when bit 41 was clear. When bit 41 was set it performs no write and reports `done_conflict`=1.
- R8: `done` is a single-cycle pulse per accepted command. `done_conflict` is high only together with `done`, and is 0 for operations 0 to 2.
- R9: A command offered while a command is in progress, including in the cycle `done` is high, is ignored. It produces no bus access, no entry change and no `done`.
- R10: A write-back carries the entry as read, with only the operation's flag bits set. All other bits are preserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_addr | input | ADDR_W | Byte address of the 64-bit entry |
| cmd_op | input | 2 | Operation: 0 segment access, 1 page read access, 2 page write access, 3 task claim |
| cmd_legacy | input | 1 | Always write back for operation 0 |
| mem_lock | output | 1 | Locked bus ownership request, held for the whole update |
| mem_gnt | input | 1 | Locked ownership granted |
| mem_req | output | 1 | Memory access request, held until `mem_ack` |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Access complete; read data valid this cycle |
| mem_rdata | input | DATA_W | Read data |
| done | output | 1 | Command finished (one-cycle pulse) |
| done_conflict | output | 1 | Task claim found the busy flag already set |

## Verification
Two events can fall in the same cycle: a new command arriving, and the completion pulse of the previous one. The bench offers a command exactly in a `done` cycle, with and without grant and acknowledge delays. It judges the result by confirming that the offered entry stays unchanged and that no extra completion ever appears. A second intrusion, offered while the engine waits for its grant, is judged the same way. Every completed update is compared with a scoreboard entry holding the expected entry value, the conflict flag and the number of write cycles seen on the memory port.

// File: rtl/afu_pkg.sv
// Shared types for the locked flag updater.
package afu_pkg;
    // Operation codes carried on cmd_op.
    typedef enum logic [1:0] {
        OP_SEG_ACC    = 2'd0,
        OP_PG_READ    = 2'd1,
        OP_PG_WRITE   = 2'd2,
        OP_TASK_CLAIM = 2'd3
    } afu_op_e;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB,
        ST_READ,
        ST_CALC,
        ST_WRITE,
        ST_DONE
    } afu_state_e;
endpackage

// File: rtl/afu_cmd_latch.sv
// Command capture register.
// Holds address, operation and legacy select of the accepted command.
// Assumes capture is high only when the sequencer is idle.
module afu_cmd_latch
    import afu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_legacy,
    output logic [ADDR_W-1:0] addr_q,
    output afu_op_e           op_q,
    output logic              legacy_q
);
    // Purpose: store the command fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            op_q     <= OP_SEG_ACC;
            legacy_q <= 1'b0;
        end else if (capture) begin
            addr_q   <= cmd_addr;
            op_q     <= afu_op_e'(cmd_op);
            legacy_q <= cmd_legacy;
        end
    end
endmodule

// File: rtl/afu_flag_calc.sv
// Combinational update rule.
// From the entry as read, the operation and the legacy select, derives:
//   the new entry value, whether a write is needed, and the claim conflict.
// Assumes every bit position parameter lies inside DATA_W.
module afu_flag_calc
    import afu_pkg::*;
#(
    parameter int DATA_W        = 64,
    parameter int SEG_ACC_BIT   = 40,
    parameter int PG_ACC_BIT    = 5,
    parameter int PG_DIRTY_BIT  = 6,
    parameter int TASK_BUSY_BIT = 41
) (
    input  afu_op_e           op,
    input  logic              legacy,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] wdata,
    output logic              need_write,
    output logic              conflict
);
    localparam logic [DATA_W-1:0] ONE        = {{(DATA_W-1){1'b0}}, 1'b1};
    localparam logic [DATA_W-1:0] SEG_MASK   = ONE << SEG_ACC_BIT;
    localparam logic [DATA_W-1:0] PGR_MASK   = ONE << PG_ACC_BIT;
    localparam logic [DATA_W-1:0] PGW_MASK   = (ONE << PG_ACC_BIT) | (ONE << PG_DIRTY_BIT);
    localparam logic [DATA_W-1:0] BUSY_MASK  = ONE << TASK_BUSY_BIT;

    logic [DATA_W-1:0] set_mask;
    logic              all_set;

    // Purpose: choose the flag bits this operation sets.
    always_comb begin
        case (op)
            OP_SEG_ACC:  set_mask = SEG_MASK;
            OP_PG_READ:  set_mask = PGR_MASK;
            OP_PG_WRITE: set_mask = PGW_MASK;
            default:     set_mask = BUSY_MASK;
        endcase
    end

    assign all_set = ((rdata & set_mask) == set_mask);
    assign wdata   = rdata | set_mask;

    // Purpose: decide write-back and conflict from the current flag state.
    always_comb begin
        conflict   = 1'b0;
        need_write = !all_set;
        if (op == OP_SEG_ACC && legacy) begin
            need_write = 1'b1;
        end
        if (op == OP_TASK_CLAIM) begin
            conflict = all_set;
        end
    end
endmodule

// File: rtl/afu_sequencer.sv
// Locked read-modify-write sequencer.
// Order: idle -> await grant under lock -> read -> decide -> optional write -> done.
// Assumes mem_gnt stays high while mem_lock is held once granted,
// and mem_ack is a one-cycle response to a held mem_req.
module afu_sequencer
    import afu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic mem_gnt,
    input  logic mem_ack,
    input  logic need_write,
    output logic capture,
    output logic load_rdata,
    output logic decide,
    output logic mem_lock,
    output logic mem_req,
    output logic mem_we,
    output logic done
);
    afu_state_e state_q, state_d;

    // Purpose: next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (cmd_valid) state_d = ST_ARB;
            ST_ARB:   if (mem_gnt)   state_d = ST_READ;
            ST_READ:  if (mem_ack)   state_d = ST_CALC;
            ST_CALC:  state_d = need_write ? ST_WRITE : ST_DONE;
            ST_WRITE: if (mem_ack)   state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Purpose: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Purpose: decode per-state controls and outputs.
    always_comb begin
        mem_lock = 1'b0;
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        done     = 1'b0;
        case (state_q)
            ST_ARB:   mem_lock = 1'b1;
            ST_READ:  begin mem_lock = 1'b1; mem_req = 1'b1; end
            ST_CALC:  mem_lock = 1'b1;
            ST_WRITE: begin mem_lock = 1'b1; mem_req = 1'b1; mem_we = 1'b1; end
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end

    assign capture    = (state_q == ST_IDLE) && cmd_valid;
    assign load_rdata = (state_q == ST_READ) && mem_ack;
    assign decide     = (state_q == ST_CALC);

    // R2: a memory access only happens under lock
    a_r2_req_under_lock: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_lock);
    // R2: the read starts only after the grant
    a_r2_read_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> mem_gnt);
    // R2: lock is released in the done cycle
    a_r2_unlocked_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_lock);
    // R8: done lasts one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R2: lock is not dropped before done
    a_r2_lock_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_lock) |-> done);
endmodule

// File: rtl/flag_lock_engine.sv
// Locked flag updater top.
// Accepts one command at a time and performs a locked read, a flag decision and
// an optional write-back on a 64-bit table entry.
// Assumes the bus arbiter keeps mem_gnt high while mem_lock is held.
module flag_lock_engine
    import afu_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int DATA_W        = 64,
    parameter int SEG_ACC_BIT   = 40,
    parameter int PG_ACC_BIT    = 5,
    parameter int PG_DIRTY_BIT  = 6,
    parameter int TASK_BUSY_BIT = 41
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_legacy,
    output logic              mem_lock,
    input  logic              mem_gnt,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              done_conflict
);
    logic              capture, load_rdata, decide;
    logic [ADDR_W-1:0] addr_q;
    afu_op_e           op_q;
    logic              legacy_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] calc_wdata;
    logic              calc_need_write, calc_conflict;
    logic              conflict_q;

    afu_cmd_latch #(.ADDR_W(ADDR_W)) cmd_i (
        .clk(clk), .rst_n(rst_n), .capture(capture),
        .cmd_addr(cmd_addr), .cmd_op(cmd_op), .cmd_legacy(cmd_legacy),
        .addr_q(addr_q), .op_q(op_q), .legacy_q(legacy_q)
    );

    afu_flag_calc #(
        .DATA_W(DATA_W), .SEG_ACC_BIT(SEG_ACC_BIT), .PG_ACC_BIT(PG_ACC_BIT),
        .PG_DIRTY_BIT(PG_DIRTY_BIT), .TASK_BUSY_BIT(TASK_BUSY_BIT)
    ) calc_i (
        .op(op_q), .legacy(legacy_q), .rdata(rdata_q),
        .wdata(calc_wdata), .need_write(calc_need_write), .conflict(calc_conflict)
    );

    afu_sequencer seq_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
        .mem_gnt(mem_gnt), .mem_ack(mem_ack), .need_write(calc_need_write),
        .capture(capture), .load_rdata(load_rdata), .decide(decide),
        .mem_lock(mem_lock), .mem_req(mem_req), .mem_we(mem_we), .done(done)
    );

    // Purpose: hold the entry as read for the decision and the write-back.
    always_ff @(posedge clk) begin
        if (!rst_n)          rdata_q <= '0;
        else if (load_rdata) rdata_q <= mem_rdata;
    end

    // Purpose: keep the claim conflict from the decision until done.
    always_ff @(posedge clk) begin
        if (!rst_n)      conflict_q <= 1'b0;
        else if (decide) conflict_q <= calc_conflict;
    end

    assign mem_addr      = addr_q;
    assign mem_wdata     = calc_wdata;
    assign done_conflict = done && conflict_q;

    // R8: conflict is reported only with done
    a_r8_conflict_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_conflict |-> done);
    // R7: a conflicting claim never reaches the write cycle
    a_r7_conflict_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && calc_conflict) |=> !mem_req);
    // R9: the entry address stays put while the bus is held
    a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_lock && $past(mem_lock)) |-> $stable(mem_addr));
    // R3: a skipped write only happens when the entry already holds its flags
    a_r3_skip_only_when_set: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && !calc_need_write) |-> (calc_wdata == rdata_q));
endmodule

// File: tb/flag_lock_engine_tb_top.sv
`timescale 1ns/1ps
module flag_lock_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_addr = '0;
    logic [1:0]  cmd_op = '0;
    logic        cmd_legacy = 1'b0;
    logic        mem_lock, mem_req, mem_we;
    logic        mem_gnt = 1'b0;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata;
    logic [63:0] mem_rdata = '0;
    logic        done, done_conflict;

    always #4 clk = ~clk;

    flag_lock_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .cmd_op(cmd_op), .cmd_legacy(cmd_legacy), .mem_lock(mem_lock),
        .mem_gnt(mem_gnt), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .done(done), .done_conflict(done_conflict)
    );

    localparam logic [63:0] B5  = 64'h1 << 5;
    localparam logic [63:0] B6  = 64'h1 << 6;
    localparam logic [63:0] B40 = 64'h1 << 40;
    localparam logic [63:0] B41 = 64'h1 << 41;

    typedef struct {
        int          idx;
        logic [63:0] exp_val;
        bit          exp_conf;
        int          exp_writes;
        string       req;
    } item_t;

    item_t       sb[$];
    logic [63:0] mem [16];
    int gdelay = 0, alat = 0, gcnt = 0, acnt = 0;
    int wr_count = 0, wr_seen = 0;
    int checks = 0, failures = 0;
    int done_total = 0, cmd_total = 0;
    int lock_viol = 0, pulse_viol = 0;
    logic done_prev = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Memory and arbiter model: grant after gdelay cycles of lock, ack after alat cycles.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_gnt <= 1'b0; mem_ack <= 1'b0; gcnt <= 0; acnt <= 0;
        end else begin
            if (mem_lock) begin
                if (gcnt >= gdelay) mem_gnt <= 1'b1;
                else                gcnt <= gcnt + 1;
            end else begin
                mem_gnt <= 1'b0; gcnt <= 0;
            end
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                if (acnt >= alat) begin
                    mem_ack <= 1'b1; acnt <= 0;
                    if (mem_we) begin
                        mem[mem_addr[6:3]] <= mem_wdata;
                        wr_count <= wr_count + 1;
                    end else begin
                        mem_rdata <= mem[mem_addr[6:3]];
                    end
                end else begin
                    acnt <= acnt + 1;
                end
            end
        end
    end

    // Protocol watcher at each edge (R2, R8).
    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_req && !(mem_lock && mem_gnt)) lock_viol++;
            if (done && mem_lock) lock_viol++;
            if (done && done_prev) pulse_viol++;
            if (done_conflict && !done) pulse_viol++;
            done_prev <= done;
        end
    end

    // Scoreboard monitor: compare each completion with the queued expectation.
    always @(negedge clk) begin
        if (rst_n && done) begin
            item_t it;
            done_total++;
            if (sb.size() == 0) begin
                chk(1'b0, "R9", "unexpected done", 64'd1, 64'd0);
            end else begin
                it = sb.pop_front();
                chk(mem[it.idx] == it.exp_val, it.req, "entry value", mem[it.idx], it.exp_val);
                chk(done_conflict == it.exp_conf, it.req, "conflict", 64'(done_conflict), 64'(it.exp_conf));
                chk((wr_count - wr_seen) == it.exp_writes, it.req, "write cycles",
                    64'(wr_count - wr_seen), 64'(it.exp_writes));
                wr_seen = wr_count;
            end
        end
    end

    // Reference rule computed from the requirements.
    function automatic void model(input int op, input bit leg, input logic [63:0] old,
                                  output logic [63:0] nv, output bit conf, output int wr);
        logic [63:0] m;
        bit need;
        conf = 1'b0;
        case (op)
            0:       begin m = B40;     need = leg || !old[40]; end
            1:       begin m = B5;      need = !old[5]; end
            2:       begin m = B5 | B6; need = !(old[5] && old[6]); end
            default: begin m = B41;     need = !old[41]; conf = old[41]; end
        endcase
        nv = need ? (old | m) : old;
        wr = need ? 1 : 0;
    endfunction

    // Driver: queue the expectation, offer the command, optionally intrude.
    // race 1: intrusion while waiting for grant; race 2: intrusion in the done cycle.
    task automatic issue(input int op, input bit leg, input int idx,
                         input logic [63:0] init, input int race, input string req);
        item_t it;
        @(negedge clk);
        mem[idx] = init;
        mem[15]  = 64'h0;
        it.idx = idx; it.req = req;
        model(op, leg, init, it.exp_val, it.exp_conf, it.exp_writes);
        sb.push_back(it);
        cmd_total++;
        cmd_valid = 1'b1; cmd_op = op[1:0]; cmd_addr = 32'(idx * 8); cmd_legacy = leg;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (race == 1) begin
            cmd_valid = 1'b1; cmd_op = 2'd0; cmd_addr = 32'(15 * 8); cmd_legacy = 1'b1;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        while (!done) @(negedge clk);
        if (race == 2) begin
            cmd_valid = 1'b1; cmd_op = 2'd0; cmd_addr = 32'(15 * 8); cmd_legacy = 1'b1;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        if (race != 0) begin
            repeat (6) @(negedge clk);
            chk(mem[15] == 64'h0, "R9", "intruding command changed entry", mem[15], 64'h0);
            chk(done_total == cmd_total, "R9", "done count after intrusion",
                64'(done_total), 64'(cmd_total));
        end
    endtask

    localparam logic [63:0] P1 = 64'hA5C3_0F1E_7B2D_9864;
    localparam logic [63:0] P2 = 64'h1234_5678_9ABC_DEF0;

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 64'h0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(done == 1'b0, "R1", "done at reset", 64'(done), 64'd0);
        chk(done_conflict == 1'b0, "R1", "conflict at reset", 64'(done_conflict), 64'd0);
        chk(mem_lock == 1'b0, "R1", "lock at reset", 64'(mem_lock), 64'd0);
        chk(mem_req == 1'b0, "R1", "req at reset", 64'(mem_req), 64'd0);
        rst_n = 1'b1;

        issue(0, 1'b0, 1, P1 & ~B40, 0, "R3");   // clear -> written
        issue(0, 1'b0, 2, P2 | B40,  0, "R3");   // set -> no write
        issue(0, 1'b1, 3, P1 | B40,  0, "R4");   // legacy, set -> written anyway
        issue(0, 1'b1, 4, P2 & ~B40, 0, "R4");
        gdelay = 3; alat = 2;
        issue(1, 1'b0, 5, P1 & ~B5, 0, "R5");
        issue(1, 1'b1, 6, P2 | B5,  0, "R5");    // legacy has no effect on op 1
        issue(2, 1'b0, 7, P1 & ~(B5 | B6), 0, "R6");
        issue(2, 1'b0, 8, (P2 | B5) & ~B6, 0, "R6");
        issue(2, 1'b0, 9, P1 | B5 | B6,    0, "R6");
        gdelay = 0; alat = 1;
        issue(3, 1'b0, 10, P2 & ~B41, 0, "R7");  // claim succeeds
        issue(3, 1'b0, 11, P1 | B41,  0, "R7");  // claim conflicts
        issue(3, 1'b1, 12, 64'h0,     0, "R10"); // only bit 41 changes
        // R9: intrusion while waiting for grant and in the done cycle
        gdelay = 4; alat = 0;
        issue(0, 1'b0, 13, P2 & ~B40, 1, "R9");
        gdelay = 0; alat = 0;
        issue(3, 1'b0, 14, P1 | B41,  2, "R9");
        gdelay = 2; alat = 3;
        issue(2, 1'b0, 1, 64'h0,      2, "R9");

        repeat (4) @(negedge clk);
        chk(lock_viol == 0, "R2", "lock protocol violations", 64'(lock_viol), 64'd0);
        chk(pulse_viol == 0, "R8", "done pulse violations", 64'(pulse_viol), 64'd0);
        chk(sb.size() == 0, "R8", "missing completions", 64'(sb.size()), 64'd0);
        chk(done_total == cmd_total, "R8", "completion count", 64'(done_total), 64'(cmd_total));
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule